// File: doc/BRIEF.md
# Signed Power-of-Two Rounding Scaler

The block divides a two's-complement data word by 2^k, where the shift amount k arrives with every sample. A two-bit mode input picks how the bits shifted out are resolved. The choices are rounding down toward minus infinity, cutting toward zero, or going to the nearest integer with exact halves pushed away from zero. A fourth mode treats the word as unsigned and shifts in zeros. It is there so signed and unsigned results can be compared side by side.

A single datapath covers all four modes. The input is widened by one bit and a bias is added that depends on the mode and on the sign. The sum then goes through one arithmetic right shift. The result is registered with one cycle of latency. A sticky flag is registered with it, and that flag reports whether any of the discarded low bits was set.

Top module: `pow2_round_scaler`

## Requirements
- R1: With mode code 2'b00 (floor), the output equals floor(x / 2^k); for example -5 with k=1 gives -3.
- R2: With mode code 2'b01 (toward zero), the output equals x / 2^k with the fraction dropped toward zero; for example -5 with k=1 gives -2 and -7 with k=2 gives -1.
- R3: With mode code 2'b10 (nearest), the output is the nearest integer to x / 2^k, and exact halves go away from zero; for example -384 with k=8 gives -2, 384 with k=8 gives 2, and -6 with k=2 gives -2.
- R4: With mode code 2'b11 (logical), the input is read as unsigned and zeros fill the top; for example 16'hFFFF with k=4 gives 16'h0FFF.
- R5: When k=0, every mode passes the input through unchanged and the inexact flag is low.
- R6: out_inexact is high exactly when at least one of the k low bits of the input is 1.
- R7: Adding the rounding bias never wraps: 16'h7FFF with k=1 in nearest mode gives 16'h4000, and 16'h7FFF with k=15 gives 1.
- R8: Outputs change only on a rising clock edge, one cycle after the inputs are applied. While rst_n is low, both outputs read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_data | input | DATA_W | Data word (two's complement except in logical mode) |
| in_shift | input | SH_W | Shift amount k, 0 to DATA_W-1 |
| in_mode | input | 2 | 00 floor, 01 toward zero, 10 nearest, 11 logical |
| out_data | output | DATA_W | Scaled result, registered |
| out_inexact | output | 1 | High when discarded bits were nonzero, registered |

## Verification
The assertions assume that every input is driven to a known value at every clock edge after reset. They also assume that in_shift stays below DATA_W, which the port width guarantees for a power-of-two DATA_W. They compare each registered output with the inputs one edge earlier. Because of that, the checker only arms after one full clock out of reset. The bench changes inputs only on the falling edge, and it holds reset until inputs have known values, so every sampled input is defined and stable.

// File: rtl/scl_pkg.sv
package scl_pkg;

    typedef enum logic [1:0] {
        MD_FLOOR   = 2'b00,
        MD_TOZERO  = 2'b01,
        MD_NEAREST = 2'b10,
        MD_LOGICAL = 2'b11
    } scl_mode_e;

endpackage

// File: rtl/scl_lowbits.sv
module scl_lowbits #(
    parameter int DATA_W = 16,
    parameter int SH_W   = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] in_data,
    input  logic [SH_W-1:0]   in_shift,
    output logic [DATA_W-1:0] lsb_mask,
    output logic [DATA_W-1:0] half_bit,
    output logic              sticky
);
    // lsb_mask marks the k positions shifted out; half_bit marks position k-1
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        assign lsb_mask[i] = (i < int'(in_shift));
        assign half_bit[i] = ((i + 1) == int'(in_shift));
    end

    assign sticky = |(in_data & lsb_mask);

endmodule

// File: rtl/scl_bias.sv
module scl_bias
    import scl_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  scl_mode_e         mode,
    input  logic              neg,
    input  logic [DATA_W-1:0] lsb_mask,
    input  logic [DATA_W-1:0] half_bit,
    output logic [DATA_W:0]   bias
);
    localparam int EXT_W = DATA_W + 1;

    always_comb begin
        bias = '0;
        unique case (mode)
            MD_FLOOR:   bias = '0;
            // negative values: add 2^k-1 so the floor shift truncates toward zero
            MD_TOZERO:  bias = neg ? EXT_W'(lsb_mask) : '0;
            // nonnegative: +2^(k-1); negative: +2^(k-1)-1 sends ties downward
            MD_NEAREST: bias = neg ? EXT_W'(lsb_mask >> 1) : EXT_W'(half_bit);
            MD_LOGICAL: bias = '0;
        endcase
    end

endmodule

// File: rtl/scl_shift.sv
module scl_shift #(
    parameter int DATA_W = 16,
    parameter int SH_W   = $clog2(DATA_W)
) (
    input  logic [DATA_W:0]   sum_ext,
    input  logic [SH_W-1:0]   in_shift,
    output logic [DATA_W-1:0] shifted
);
    logic signed [DATA_W:0] sum_s;
    logic signed [DATA_W:0] shr_s;

    assign sum_s   = $signed(sum_ext);
    assign shr_s   = sum_s >>> in_shift;
    assign shifted = shr_s[DATA_W-1:0];

endmodule

// File: rtl/pow2_round_scaler.sv
module pow2_round_scaler
    import scl_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int SH_W   = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] in_data,
    input  logic [SH_W-1:0]   in_shift,
    input  logic [1:0]        in_mode,
    output logic [DATA_W-1:0] out_data,
    output logic              out_inexact
);
    localparam int MSB = DATA_W - 1;

    scl_mode_e         mode;
    logic              top_fill;
    logic [DATA_W:0]   ext_data;
    logic [DATA_W-1:0] lsb_mask;
    logic [DATA_W-1:0] half_bit;
    logic              sticky;
    logic [DATA_W:0]   bias;
    logic [DATA_W:0]   sum_ext;
    logic [DATA_W-1:0] shifted;

    assign mode = scl_mode_e'(in_mode);

    always_comb begin
        top_fill = 1'b0;
        unique case (mode)
            MD_LOGICAL: top_fill = 1'b0;
            default:    top_fill = in_data[MSB];
        endcase
    end

    assign ext_data = {top_fill, in_data};

    scl_lowbits #(.DATA_W(DATA_W), .SH_W(SH_W)) u_lowbits (
        .in_data  (in_data),
        .in_shift (in_shift),
        .lsb_mask (lsb_mask),
        .half_bit (half_bit),
        .sticky   (sticky)
    );

    scl_bias #(.DATA_W(DATA_W)) u_bias (
        .mode     (mode),
        .neg      (top_fill),
        .lsb_mask (lsb_mask),
        .half_bit (half_bit),
        .bias     (bias)
    );

    // one guard bit: the bias cannot wrap the sum
    assign sum_ext = ext_data + bias;

    scl_shift #(.DATA_W(DATA_W), .SH_W(SH_W)) u_shift (
        .sum_ext  (sum_ext),
        .in_shift (in_shift),
        .shifted  (shifted)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_data    <= '0;
            out_inexact <= 1'b0;
        end else begin
            out_data    <= shifted;
            out_inexact <= sticky;
        end
    end

endmodule

// File: rtl/pow2_round_scaler_chk.sv
module pow2_round_scaler_chk #(
    parameter int DATA_W = 16,
    parameter int SH_W   = $clog2(DATA_W)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] in_data,
    input logic [SH_W-1:0]   in_shift,
    input logic [1:0]        in_mode,
    input logic [DATA_W-1:0] out_data,
    input logic              out_inexact
);
    localparam int MSB = DATA_W - 1;

    logic armed;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    logic signed [DATA_W:0] in_abs;
    logic signed [DATA_W:0] out_abs;
    assign in_abs  = in_data[MSB]  ? -$signed({1'b1, in_data})  : $signed({1'b0, in_data});
    assign out_abs = out_data[MSB] ? -$signed({1'b1, out_data}) : $signed({1'b0, out_data});

    logic signed [DATA_W:0] in_abs_q;
    always_ff @(posedge clk) in_abs_q <= in_abs;

    p_floor_neg_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(in_mode) == 2'b00 && $past(in_data[MSB])) |-> out_data[MSB]);

    p_tozero_mag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(in_mode) == 2'b01) |-> (out_abs <= in_abs_q));

    p_near_nonneg_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(in_mode) == 2'b10 && !$past(in_data[MSB])) |-> !out_data[MSB]);

    p_logic_zero_top_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(in_mode) == 2'b11 && $past(in_shift) != '0) |-> !out_data[MSB]);

    p_pass_k0_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(in_shift) == '0) |-> (out_data == $past(in_data) && !out_inexact));

    p_exact_back_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !out_inexact && $past(in_mode) != 2'b11)
            |-> ((out_data << $past(in_shift)) == $past(in_data)));

    p_reset_zero_r8: assert property (@(posedge clk)
        !rst_n |-> (out_data == '0 && !out_inexact));

endmodule

bind pow2_round_scaler pow2_round_scaler_chk #(.DATA_W(DATA_W), .SH_W(SH_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_data     (in_data),
    .in_shift    (in_shift),
    .in_mode     (in_mode),
    .out_data    (out_data),
    .out_inexact (out_inexact)
);

// File: tb/pow2_round_scaler_tb.sv
`timescale 1ns/1ps
module pow2_round_scaler_tb;
    localparam int DATA_W = 16;
    localparam int SH_W   = 4;
    localparam int NV     = 33;

    // {data, shift, mode, expected, expected_inexact}
    localparam logic [38:0] VEC [NV] = '{
        {16'hFFFB, 4'd1,  2'b00, 16'hFFFD, 1'b1},
        {16'hFFFB, 4'd1,  2'b01, 16'hFFFE, 1'b1},
        {16'hFFFB, 4'd1,  2'b10, 16'hFFFD, 1'b1},
        {16'h0005, 4'd1,  2'b10, 16'h0003, 1'b1},
        {16'h0005, 4'd1,  2'b00, 16'h0002, 1'b1},
        {16'h0005, 4'd1,  2'b01, 16'h0002, 1'b1},
        {16'hFE80, 4'd8,  2'b10, 16'hFFFE, 1'b1},
        {16'h0180, 4'd8,  2'b10, 16'h0002, 1'b1},
        {16'hFF81, 4'd8,  2'b10, 16'h0000, 1'b1},
        {16'h017F, 4'd8,  2'b10, 16'h0001, 1'b1},
        {16'hFF00, 4'd8,  2'b01, 16'hFFFF, 1'b0},
        {16'hFF00, 4'd8,  2'b00, 16'hFFFF, 1'b0},
        {16'hFFFF, 4'd4,  2'b00, 16'hFFFF, 1'b1},
        {16'hFFFF, 4'd4,  2'b01, 16'h0000, 1'b1},
        {16'hFFFF, 4'd4,  2'b10, 16'h0000, 1'b1},
        {16'hFFFF, 4'd4,  2'b11, 16'h0FFF, 1'b1},
        {16'h8000, 4'd15, 2'b00, 16'hFFFF, 1'b0},
        {16'h8000, 4'd15, 2'b01, 16'hFFFF, 1'b0},
        {16'h8000, 4'd15, 2'b10, 16'hFFFF, 1'b0},
        {16'h8000, 4'd15, 2'b11, 16'h0001, 1'b0},
        {16'h7FFF, 4'd15, 2'b00, 16'h0000, 1'b1},
        {16'hFFF9, 4'd0,  2'b00, 16'hFFF9, 1'b0},
        {16'hFFF9, 4'd0,  2'b01, 16'hFFF9, 1'b0},
        {16'hFFF9, 4'd0,  2'b10, 16'hFFF9, 1'b0},
        {16'hFFF9, 4'd0,  2'b11, 16'hFFF9, 1'b0},
        {16'h8000, 4'd1,  2'b01, 16'hC000, 1'b0},
        {16'h8001, 4'd1,  2'b10, 16'hC000, 1'b1},
        {16'h0007, 4'd2,  2'b01, 16'h0001, 1'b1},
        {16'hFFF9, 4'd2,  2'b01, 16'hFFFF, 1'b1},
        {16'hFFF9, 4'd2,  2'b00, 16'hFFFE, 1'b1},
        {16'hFFF9, 4'd2,  2'b10, 16'hFFFE, 1'b1},
        {16'hFFFA, 4'd2,  2'b10, 16'hFFFE, 1'b1},
        {16'h0006, 4'd2,  2'b10, 16'h0002, 1'b1}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [DATA_W-1:0] in_data = '0;
    logic [SH_W-1:0]   in_shift = '0;
    logic [1:0]        in_mode = '0;
    logic [DATA_W-1:0] out_data;
    logic              out_inexact;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    pow2_round_scaler #(.DATA_W(DATA_W), .SH_W(SH_W)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_data     (in_data),
        .in_shift    (in_shift),
        .in_mode     (in_mode),
        .out_data    (out_data),
        .out_inexact (out_inexact)
    );

    task automatic check(input string req, input string what,
                         input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic string mode_req(input logic [1:0] m, input logic [SH_W-1:0] k);
        if (k == 0)       return "R5";
        case (m)
            2'b00:   return "R1";
            2'b01:   return "R2";
            2'b10:   return "R3";
            default: return "R4";
        endcase
    endfunction

    task automatic apply(input logic [DATA_W-1:0] d, input logic [SH_W-1:0] k,
                         input logic [1:0] m);
        @(negedge clk);
        in_data  = d;
        in_shift = k;
        in_mode  = m;
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL R8 watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R8: reset state
        check("R8", "reset data", out_data, '0);
        check("R8", "reset inexact", {15'd0, out_inexact}, 16'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][38:23], VEC[i][22:19], VEC[i][18:17]);
            check(mode_req(VEC[i][18:17], VEC[i][22:19]), "data", out_data, VEC[i][16:1]);
            check("R6", "inexact", {15'd0, out_inexact}, {15'd0, VEC[i][0]});
        end

        // R7: bias must not wrap at the positive limit
        apply(16'h7FFF, 4'd1, 2'b10);
        check("R7", "max k1 nearest", out_data, 16'h4000);
        apply(16'h7FFF, 4'd15, 2'b10);
        check("R7", "max k15 nearest", out_data, 16'h0001);

        // R6: only a set bit above the k low bits leaves the flag low
        apply(16'h0010, 4'd4, 2'b00);
        check("R6", "bit k set only", {15'd0, out_inexact}, 16'd0);
        apply(16'h0008, 4'd4, 2'b00);
        check("R6", "bit k-1 set", {15'd0, out_inexact}, 16'd1);

        // R8: output holds until the next rising edge
        @(negedge clk);
        in_data  = 16'h0100;
        in_shift = 4'd8;
        in_mode  = 2'b00;
        #1;
        check("R8", "hold before edge", out_data, 16'h0000);
        @(negedge clk);
        check("R8", "one cycle latency", out_data, 16'h0001);

        // R8: reset clears a nonzero result
        apply(16'hFFFF, 4'd4, 2'b11);
        rst_n = 1'b0;
        #1;
        check("R8", "reset clears data", out_data, '0);
        check("R8", "reset clears inexact", {15'd0, out_inexact}, 16'd0);
        @(negedge clk);
        rst_n = 1'b1;
        apply(16'hFFFB, 4'd1, 2'b01);
        check("R2", "after reset", out_data, 16'hFFFE);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule